// File: doc/BRIEF.md
# CD Subcode Q-Channel Extractor

This block takes the user-data bits recovered from each received audio frame, one bit per strobe, and rebuilds the compact-disc subcode symbols carried in them. Each symbol begins with a 1 marker bit. Seven payload bits follow, and the first of the seven is the Q bit. A short run of 0 bits may come before the next marker. The block finds the start of each subcode block from its two all-zero sync symbols. It then collects the Q bit of each of the 96 data symbols that follow.

When the last data symbol of a block has arrived, the block checks the CRC-16 that the block carries. It then publishes the 80 payload bits as ten 8-bit bytes, together with a CRC status bit, and pulses a new-data flag. The published values change only at that pulse, so a reader never sees bytes from two different blocks. The other six bits of each symbol are skipped. A run of padding zeros that is too long is treated as lost framing, and the partial block is dropped.

Top module: `cdq_extractor`

## Requirements
- R1: A symbol is a 1 marker bit followed by seven payload bits. The first payload bit after the marker is the Q bit. The first 1 seen after a symbol ends is taken as the next marker.
- R2: Between zero and eight 0 bits may sit between the last payload bit of one symbol and the next marker, with no effect on the result.
- R3: A ninth consecutive padding 0 counts as lost framing. The partially collected block is discarded, no update pulse is produced for it, and `qbytes_o` and `crc_err_o` keep their previous values. The next marker starts a fresh search for sync.
- R4: While searching, two consecutive symbols whose seven payload bits are all 0 mark a block start. The next 96 symbols are data symbols S2..S97, carrying Q2..Q97. Symbols with a nonzero payload seen while searching are ignored.
- R5: Output byte k (k = 0..9) sits at `qbytes_o[79-8k -: 8]` and holds Q(2+8k) in its bit 7 down to Q(9+8k) in its bit 0. So byte 0 holds Q2..Q9 and byte 9 holds Q74..Q81.
- R6: The CRC uses the generator x^16+x^12+x^5+1, starts from zero, and runs over Q2..Q81 with Q2 first. The check passes when Q82..Q97 (Q82 as the most significant bit) equal the bitwise complement of the remainder. `crc_err_o` is 0 on a pass and 1 on a failure. The bytes are loaded in either case.
- R7: Every completed block raises `qnew_o` for exactly one clock cycle. `qbytes_o` and `crc_err_o` take the new block's values in that same cycle and do not change at any other time.
- R8: After reset, `qbytes_o` is all zero, `crc_err_o` is 0 and `qnew_o` is 0.
- R9: The six payload bits after the Q bit (channels R to W) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ubit_vld_i | input | 1 | Strobe: one user-data bit is present this cycle |
| ubit_i | input | 1 | User-data bit value |
| qbytes_o | output | 80 | Ten Q bytes, byte 0 in the top eight bits |
| crc_err_o | output | 1 | CRC status of the published block, 1 = failed |
| qnew_o | output | 1 | One-cycle pulse when a new block has been published |

## Verification
A wrong internal state shows at the ports in a few characteristic ways. If the framer's bit position slips, the wrong payload bit is taken as Q: the bytes come out shifted and the CRC fails, both visible at the first pulse after the slip. If sync detection or the symbol counter goes astray, the pulse comes early, late or not at all, so the bench counts pulses over every block. A corrupted CRC register flips `crc_err_o` on a block the bench knows to be good. Padding of 0 and 8 zeros, a ninth zero, nonzero symbols before a block, and deliberately broken check words are all driven as directed cases between the random blocks.

// File: rtl/cdq_pkg.sv
package cdq_pkg;
  localparam int SYM_BITS     = 7;
  localparam int MAX_PAD      = 8;
  localparam int SYNC_SYMS    = 2;
  localparam int DATA_SYMS    = 96;
  localparam int PAYLOAD_BITS = 80;
  localparam int CRC_W        = 16;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  typedef enum logic [0:0] {FR_PAD, FR_BITS} fr_state_e;
  typedef enum logic [0:0] {BK_HUNT, BK_DATA} bk_state_e;
endpackage

// File: rtl/cdq_symbol_framer.sv
module cdq_symbol_framer
  import cdq_pkg::*;
#(
  parameter int SYMBITS = SYM_BITS,
  parameter int PADMAX  = MAX_PAD
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_vld_i,
  input  logic               bit_i,
  output logic               sym_vld_o,
  output logic [SYMBITS-1:0] sym_o,
  output logic               loss_o
);
  localparam int PAD_W = $clog2(PADMAX + 1);
  localparam int BIT_W = (SYMBITS > 1) ? $clog2(SYMBITS) : 1;
  localparam logic [PAD_W-1:0] PAD_LIM  = PAD_W'(PADMAX);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SYMBITS - 1);

  fr_state_e          state_q, state_d;
  logic [PAD_W-1:0]   pad_q, pad_d;
  logic [BIT_W-1:0]   cnt_q, cnt_d;
  logic [SYMBITS-1:0] shift_q, shift_d;
  logic               sym_vld_d, loss_d;
  logic               sym_vld_q, loss_q;
  logic [SYMBITS-1:0] sym_q;

  always_comb begin
    state_d   = state_q;
    pad_d     = pad_q;
    cnt_d     = cnt_q;
    shift_d   = shift_q;
    sym_vld_d = 1'b0;
    loss_d    = 1'b0;
    if (bit_vld_i) begin
      case (state_q)
        FR_PAD: begin
          if (bit_i) begin
            state_d = FR_BITS;
            cnt_d   = '0;
            pad_d   = '0;
          end else if (pad_q == PAD_LIM) begin
            loss_d = 1'b1;
          end else begin
            pad_d = pad_q + 1'b1;
          end
        end
        default: begin
          shift_d = {shift_q[SYMBITS-2:0], bit_i};
          if (cnt_q == LAST_BIT) begin
            state_d   = FR_PAD;
            pad_d     = '0;
            sym_vld_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= FR_PAD;
      pad_q     <= '0;
      cnt_q     <= '0;
      shift_q   <= '0;
      sym_vld_q <= 1'b0;
      loss_q    <= 1'b0;
      sym_q     <= '0;
    end else begin
      state_q   <= state_d;
      pad_q     <= pad_d;
      cnt_q     <= cnt_d;
      shift_q   <= shift_d;
      sym_vld_q <= sym_vld_d;
      loss_q    <= loss_d;
      if (sym_vld_d) sym_q <= shift_d;
    end
  end

  assign sym_vld_o = sym_vld_q;
  assign sym_o     = sym_q;
  assign loss_o    = loss_q;

  // R2
  no_loss_after_sym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_q |=> !loss_q);
  // R3
  loss_needs_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loss_q) |-> $past(bit_vld_i && !bit_i));
  // R1
  sym_loss_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sym_vld_q && loss_q));
endmodule

// File: rtl/cdq_block_tracker.sv
module cdq_block_tracker
  import cdq_pkg::*;
#(
  parameter int SYMBITS = SYM_BITS,
  parameter int NSYNC   = SYNC_SYMS,
  parameter int NDATA   = DATA_SYMS,
  localparam int IDX_W  = $clog2(NDATA)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sym_vld_i,
  input  logic [SYMBITS-1:0] sym_i,
  input  logic               loss_i,
  output logic               start_o,
  output logic               qbit_vld_o,
  output logic               qbit_o,
  output logic [IDX_W-1:0]   qidx_o,
  output logic               done_o
);
  localparam int ZC_W = $clog2(NSYNC + 1);
  localparam logic [ZC_W-1:0]  ZC_LAST  = ZC_W'(NSYNC - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NDATA - 1);

  bk_state_e        state_q, state_d;
  logic [ZC_W-1:0]  zc_q, zc_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d    = state_q;
    zc_d       = zc_q;
    idx_d      = idx_q;
    start_o    = 1'b0;
    qbit_vld_o = 1'b0;
    done_o     = 1'b0;
    if (loss_i) begin
      state_d = BK_HUNT;
      zc_d    = '0;
    end else if (sym_vld_i) begin
      if (state_q == BK_HUNT) begin
        if (sym_i == '0) begin
          if (zc_q == ZC_LAST) begin
            state_d = BK_DATA;
            zc_d    = '0;
            idx_d   = '0;
            start_o = 1'b1;
          end else begin
            zc_d = zc_q + 1'b1;
          end
        end else begin
          zc_d = '0;
        end
      end else begin
        qbit_vld_o = 1'b1;
        if (idx_q == IDX_LAST) begin
          state_d = BK_HUNT;
          done_o  = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
    end
  end

  assign qbit_o = sym_i[SYMBITS-1];
  assign qidx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BK_HUNT;
      zc_q    <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      zc_q    <= zc_d;
      idx_q   <= idx_d;
    end
  end

  // R3
  loss_to_hunt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loss_i |=> (state_q == BK_HUNT));
  // R4
  start_to_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (state_q == BK_DATA && idx_q == '0));
  // R4
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BK_DATA) |-> (idx_q <= IDX_LAST));
endmodule

// File: rtl/cdq_crc_check.sv
module cdq_crc_check
  import cdq_pkg::*;
#(
  parameter int NPAY   = PAYLOAD_BITS,
  parameter int IDX_W  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             qbit_vld_i,
  input  logic             qbit_i,
  input  logic [IDX_W-1:0] qidx_i,
  output logic             crc_err_o
);
  localparam logic [IDX_W-1:0] PAY_LIM = IDX_W'(NPAY);

  logic [CRC_W-1:0] crc_q, crc_d;
  logic [CRC_W-1:0] rx_q, rx_d;
  logic             fb;

  always_comb begin
    crc_d = crc_q;
    rx_d  = rx_q;
    fb    = crc_q[CRC_W-1] ^ qbit_i;
    if (start_i) begin
      crc_d = '0;
      rx_d  = '0;
    end else if (qbit_vld_i) begin
      if (qidx_i < PAY_LIM) begin
        crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
      end else begin
        rx_d = {rx_q[CRC_W-2:0], qbit_i};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= '0;
      rx_q  <= '0;
    end else begin
      crc_q <= crc_d;
      rx_q  <= rx_d;
    end
  end

  assign crc_err_o = (rx_q != ~crc_q);

  // R6
  crc_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (crc_q == '0 && rx_q == '0));
endmodule

// File: rtl/cdq_qreg_bank.sv
module cdq_qreg_bank
  import cdq_pkg::*;
#(
  parameter int NPAY  = PAYLOAD_BITS,
  parameter int IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             qbit_vld_i,
  input  logic             qbit_i,
  input  logic [IDX_W-1:0] qidx_i,
  input  logic             done_i,
  input  logic             crc_err_i,
  output logic [NPAY-1:0]  qbytes_o,
  output logic             crc_err_o,
  output logic             new_o
);
  localparam logic [IDX_W-1:0] PAY_LIM = IDX_W'(NPAY);

  logic [NPAY-1:0] sr_q, sr_d;
  logic            load_q;
  logic [NPAY-1:0] out_q;
  logic            err_q, new_q;

  always_comb begin
    sr_d = sr_q;
    if (qbit_vld_i && (qidx_i < PAY_LIM)) sr_d = {sr_q[NPAY-2:0], qbit_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      load_q <= 1'b0;
      out_q  <= '0;
      err_q  <= 1'b0;
      new_q  <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      load_q <= done_i;
      new_q  <= load_q;
      if (load_q) begin
        out_q <= sr_q;
        err_q <= crc_err_i;
      end
    end
  end

  assign qbytes_o  = out_q;
  assign crc_err_o = err_q;
  assign new_o     = new_q;

  // R7
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_q |=> !new_q);
  // R7
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !new_q |-> ($stable(out_q) && $stable(err_q)));
  // R5
  load_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_q |-> (out_q == $past(sr_q)));
endmodule

// File: rtl/cdq_extractor.sv
module cdq_extractor
  import cdq_pkg::*;
#(
  parameter int SYMBITS  = SYM_BITS,
  parameter int PADMAX   = MAX_PAD,
  parameter int NSYNC    = SYNC_SYMS,
  parameter int NDATA    = DATA_SYMS,
  parameter int NREGS    = 10,
  parameter int RST_SYNC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ubit_vld_i,
  input  logic              ubit_i,
  output logic [NREGS*8-1:0] qbytes_o,
  output logic              crc_err_o,
  output logic              qnew_o
);
  localparam int NPAY  = NREGS * 8;
  localparam int IDX_W = $clog2(NDATA);

  logic [RST_SYNC-1:0] rst_pipe_q;
  logic                rst_n;

  generate
    if (RST_SYNC > 1) begin : g_rsync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rst_pipe_q <= '0;
        else         rst_pipe_q <= {rst_pipe_q[RST_SYNC-2:0], 1'b1};
      end
    end else begin : g_rsync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rst_pipe_q <= '0;
        else         rst_pipe_q <= 1'b1;
      end
    end
  endgenerate
  assign rst_n = rst_pipe_q[RST_SYNC-1];

  logic               sym_vld, loss;
  logic [SYMBITS-1:0] sym;
  logic               start, qbit_vld, qbit, done, crc_err;
  logic [IDX_W-1:0]   qidx;

  cdq_symbol_framer #(.SYMBITS(SYMBITS), .PADMAX(PADMAX)) u_framer (
    .clk_i(clk_i), .rst_ni(rst_n), .bit_vld_i(ubit_vld_i), .bit_i(ubit_i),
    .sym_vld_o(sym_vld), .sym_o(sym), .loss_o(loss));

  cdq_block_tracker #(.SYMBITS(SYMBITS), .NSYNC(NSYNC), .NDATA(NDATA)) u_tracker (
    .clk_i(clk_i), .rst_ni(rst_n), .sym_vld_i(sym_vld), .sym_i(sym), .loss_i(loss),
    .start_o(start), .qbit_vld_o(qbit_vld), .qbit_o(qbit), .qidx_o(qidx), .done_o(done));

  cdq_crc_check #(.NPAY(NPAY), .IDX_W(IDX_W)) u_crc (
    .clk_i(clk_i), .rst_ni(rst_n), .start_i(start), .qbit_vld_i(qbit_vld),
    .qbit_i(qbit), .qidx_i(qidx), .crc_err_o(crc_err));

  cdq_qreg_bank #(.NPAY(NPAY), .IDX_W(IDX_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_n), .qbit_vld_i(qbit_vld), .qbit_i(qbit),
    .qidx_i(qidx), .done_i(done), .crc_err_i(crc_err),
    .qbytes_o(qbytes_o), .crc_err_o(crc_err_o), .new_o(qnew_o));
endmodule

// File: tb/cdq_extractor_tb.sv
module cdq_extractor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic        ub = 1'b0;
  logic [79:0] qbytes;
  logic        crc_err, qnew;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cdq_extractor dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ubit_vld_i(vld), .ubit_i(ub),
    .qbytes_o(qbytes), .crc_err_o(crc_err), .qnew_o(qnew));

  always @(negedge clk) if (qnew) pulses++;

  function automatic logic [15:0] crc_ref(input logic [79:0] p);
    logic [15:0] c = '0;
    for (int i = 79; i >= 0; i--) begin
      logic fb = c[15] ^ p[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    vld = 1'b1; ub = b;
    @(negedge clk);
    vld = 1'b0; ub = 1'b0;
    repeat ($urandom_range(0, 1)) @(negedge clk);
  endtask

  // pad_mode: 0 random 0..8 zeros, 1 none, 2 eight
  task automatic send_sym(input logic [6:0] s, input int pad_mode);
    int npad;
    send_bit(1'b1);
    for (int i = 6; i >= 0; i--) send_bit(s[i]);
    npad = (pad_mode == 1) ? 0 : (pad_mode == 2) ? 8 : $urandom_range(0, 8);
    for (int i = 0; i < npad; i++) send_bit(1'b0);
  endtask

  task automatic send_block(input logic [79:0] pay, input logic [15:0] cw,
                            input int pad_mode, input int stop_after);
    send_sym(7'd0, pad_mode);
    send_sym(7'd0, pad_mode);
    for (int i = 0; i < 96 && i < stop_after; i++) begin
      logic q = (i < 80) ? pay[79-i] : cw[15-(i-80)];
      logic [5:0] rw = 6'($urandom);
      send_sym({q, rw}, pad_mode);
    end
  endtask

  task automatic run_block(input string req, input logic [79:0] pay,
                           input logic [15:0] cw, input int pad_mode);
    int p0 = pulses;
    logic exp_err = (cw != ~crc_ref(pay));
    send_block(pay, cw, pad_mode, 96);
    repeat (6) @(negedge clk);
    chk({req, " R7 pulse count"}, 80'(pulses - p0), 80'd1);
    chk({req, " R5 bytes"}, qbytes, pay);
    chk({req, " R6 crc status"}, 80'(crc_err), 80'(exp_err));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [79:0] pay, held;
    logic [15:0] cw;
    logic        held_err;
    int          p0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8 reset state
    chk("R8 bytes", qbytes, 80'd0);
    chk("R8 crc", 80'(crc_err), 80'd0);
    chk("R8 pulse", 80'(qnew), 80'd0);

    // R1 R2 R5 R6 good block, random padding
    pay = {$urandom, $urandom, 16'($urandom)};
    run_block("R1", pay, ~crc_ref(pay), 0);
    // R2 no padding
    pay = {$urandom, $urandom, 16'($urandom)};
    run_block("R2 pad0", pay, ~crc_ref(pay), 1);
    // R2 eight zeros everywhere
    pay = {$urandom, $urandom, 16'($urandom)};
    run_block("R2 pad8", pay, ~crc_ref(pay), 2);
    // R6 uncomplemented remainder fails
    pay = {$urandom, $urandom, 16'($urandom)};
    run_block("R6 raw rem", pay, crc_ref(pay), 0);
    // R6 one payload bit flipped after the check word was formed
    pay = 80'h0123456789abcdef0011;
    cw = ~crc_ref(pay);
    run_block("R6 flip", pay ^ 80'h1, cw, 0);
    // R6 known pattern: all-zero payload
    run_block("R6 zero", 80'd0, 16'hffff, 1);
    // R4 nonzero symbols before sync are ignored
    for (int i = 0; i < 5; i++) send_sym(7'h40 | 7'($urandom_range(0, 63)), 0);
    pay = {$urandom, $urandom, 16'($urandom)};
    run_block("R4", pay, ~crc_ref(pay), 0);
    // R9 same Q content with other R..W bits gives same outputs
    run_block("R9", pay, ~crc_ref(pay), 0);

    // R3 framing loss mid-block
    held = qbytes; held_err = crc_err;
    p0 = pulses;
    pay = {$urandom, $urandom, 16'($urandom)};
    send_block(pay, ~crc_ref(pay), 1, 40);
    for (int i = 0; i < 9; i++) send_bit(1'b0);
    for (int i = 0; i < 60; i++) send_sym(7'h40 | 7'($urandom_range(0, 63)), 0);
    repeat (6) @(negedge clk);
    chk("R3 no pulse", 80'(pulses - p0), 80'd0);
    chk("R3 bytes held", qbytes, held);
    chk("R3 crc held", 80'(crc_err), 80'(held_err));
    // R3 recovery
    pay = {$urandom, $urandom, 16'($urandom)};
    run_block("R3 recover", pay, ~crc_ref(pay), 0);

    // random blocks, some with broken check words
    for (int n = 0; n < 12; n++) begin
      pay = {$urandom, $urandom, 16'($urandom)};
      cw = ~crc_ref(pay);
      if ($urandom_range(0, 9) < 3) cw = cw ^ 16'(1 << $urandom_range(0, 15));
      run_block("R6 rand", pay, cw, 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule